// File: doc/BRIEF.md
# Accumulator Instruction Decoder

This block turns the first byte of an instruction for a small accumulator machine into control. The byte carries a five-bit operation code and a three-bit operand mode. From these the decoder works out whether a second (immediate) byte follows. It also forms the effective operand from the X, Y and A register values, the constant zero and the immediate byte. Finally it produces the control fields that the rest of the core needs to execute the instruction.

The block has no clock or state: it is a combinational decoder. The fetch logic presents the first byte, the immediate byte and the current register values, and reads back the length, the operand and the control fields in the same cycle. One register data width serves the whole block, 8 or 16 bits, chosen by parameter. Stack pops reinterpret the mode field as a destination. The high-byte move exists only in the 16-bit variant. Encodings that have no meaning raise an illegal flag.

Top module: `acc_instr_decoder`

## Requirements
- R1: `opcode` equals bits 7..3 of `instr_byte` and `mode` equals bits 2..0.
- R2: `two_byte` is 1 exactly when mode bit 2 is set; modes 000 to 011 are one-byte instructions.
- R3: For modes 000, 001, 010 and 011, `operand` is zero, X, Y and A respectively.
- R4: Mode 100 gives the immediate byte zero-extended to the data width. Modes 101, 110 and 111 give X, Y or A plus the zero-extended immediate, wrapping modulo 2 to the power of the width.
- R5: `op_class` is one-hot for every opcode, with bit 0 alu (opcodes 0 to 7), bit 1 move (8 to 12), bit 2 load (13 to 15), bit 3 store (16 to 18), bit 4 jump (19, 20), bit 5 branch (21 to 29), bit 6 push (30) and bit 7 pop (31).
- R6: `alu_func` encodes 0 none, 1 add, 2 sub, 3 add-with-carry, 4 xor, 5 and, 6 or, 7 compare, 8 shift right, 9 rotate right. Opcodes 1 to 7 select code equal to the opcode. `flags_we` is 1 for codes 1 to 9 and 0 otherwise.
- R7: Opcode 0 decodes by mode: 000 is no operation, 001 is shift right, 010 is rotate right, and modes 011 to 111 raise `illegal` with `alu_func` 0 and `flags_we` 0.
- R8: `reg_dst` encodes 0 none, 1 X, 2 Y, 3 A, 4 stack pointer. ALU results go to A, except compare and no-operation, which go nowhere. Opcodes 8, 9, 10, 11 and 12 target X, Y, A, A and the stack pointer. Loads 13, 14 and 15 target X, Y and A. Opcode 20 targets Y and sets `link_en`.
- R9: For pop (opcode 31), modes 000, 001, 010 and 011 give `reg_dst` none, X, Y and A. Modes with bit 2 set give `reg_dst` none and raise `illegal`.
- R10: Opcode 11 sets `move_high`. It raises `illegal` when the data width is 8.
- R11: For branches, `branch_cond` equals the opcode minus 21: 0 always, 1 carry clear, 2 carry set, 3 zero set, 4 zero clear, 5 negative set, 6 negative clear, 7 overflow set, 8 overflow clear. It is 0 for all other opcodes.
- R12: `store_src` is 1, 2 or 3 (X, Y, A) for opcodes 16, 17 and 18, and 0 for every other opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_byte | input | 8 | First instruction byte |
| imm_byte | input | 8 | Second instruction byte, used by modes 100 to 111 |
| reg_x | input | WIDTH | Current X value |
| reg_y | input | WIDTH | Current Y value |
| reg_a | input | WIDTH | Current accumulator value |
| opcode | output | 5 | Operation code field |
| mode | output | 3 | Operand mode field |
| two_byte | output | 1 | Instruction carries an immediate byte |
| operand | output | WIDTH | Effective operand |
| op_class | output | 8 | One-hot instruction class |
| alu_func | output | 4 | ALU operation code |
| flags_we | output | 1 | Instruction updates the flags |
| reg_dst | output | 3 | Register written by the instruction |
| store_src | output | 2 | Register stored to memory |
| move_high | output | 1 | Operand goes to the high byte of A |
| link_en | output | 1 | Return address is written to Y |
| branch_cond | output | 4 | Branch condition code |
| illegal | output | 1 | Encoding has no meaning |

## Verification
Since the decoder holds no state, a wrong mapping shows at the ports in the same cycle in which the byte is applied, and nothing carries it forward. A bad operand path shows as a wrong value in `operand`, most often as a missing zero-extension or a wrap that goes wrong on a register-plus-immediate mode. A wrong class decode shows as a class vector with zero or two bits set, or as a destination that does not match the class. The bench therefore applies each byte and compares every output field before the next byte arrives. It covers the edges of each opcode range, both data widths and the illegal encodings.

// File: rtl/accdec_pkg.sv
package accdec_pkg;

    localparam int CLASS_N = 8;

    typedef enum logic [2:0] {
        CL_ALU    = 3'd0,
        CL_MOVE   = 3'd1,
        CL_LOAD   = 3'd2,
        CL_STORE  = 3'd3,
        CL_JUMP   = 3'd4,
        CL_BRANCH = 3'd5,
        CL_PUSH   = 3'd6,
        CL_POP    = 3'd7
    } op_class_e;

    typedef enum logic [3:0] {
        AF_NONE = 4'd0,
        AF_ADD  = 4'd1,
        AF_SUB  = 4'd2,
        AF_ADC  = 4'd3,
        AF_XOR  = 4'd4,
        AF_AND  = 4'd5,
        AF_OR   = 4'd6,
        AF_CMP  = 4'd7,
        AF_SHR  = 4'd8,
        AF_ROTR = 4'd9
    } alu_func_e;

    typedef enum logic [2:0] {
        RD_NONE = 3'd0,
        RD_X    = 3'd1,
        RD_Y    = 3'd2,
        RD_A    = 3'd3,
        RD_SP   = 3'd4
    } reg_dst_e;

    typedef enum logic [2:0] {
        MD_ZERO  = 3'd0,
        MD_X     = 3'd1,
        MD_Y     = 3'd2,
        MD_A     = 3'd3,
        MD_IMM   = 3'd4,
        MD_X_IMM = 3'd5,
        MD_Y_IMM = 3'd6,
        MD_A_IMM = 3'd7
    } mode_e;

    localparam logic [4:0] OPC_SPECIAL = 5'd0;
    localparam logic [4:0] OPC_CMP     = 5'd7;
    localparam logic [4:0] OPC_MVX     = 5'd8;
    localparam logic [4:0] OPC_MVY     = 5'd9;
    localparam logic [4:0] OPC_MVA     = 5'd10;
    localparam logic [4:0] OPC_MVHI    = 5'd11;
    localparam logic [4:0] OPC_SPSET   = 5'd12;
    localparam logic [4:0] OPC_LD_LAST = 5'd15;
    localparam logic [4:0] OPC_ST_LAST = 5'd18;
    localparam logic [4:0] OPC_JLINK   = 5'd20;
    localparam logic [4:0] OPC_BR_FIRST = 5'd21;
    localparam logic [4:0] OPC_BR_LAST  = 5'd29;
    localparam logic [4:0] OPC_PUSH    = 5'd30;

    typedef struct packed {
        logic [CLASS_N-1:0] cls;
        alu_func_e          func;
        logic               flags_we;
        reg_dst_e           dst;
        logic [1:0]         store_src;
        logic               move_high;
        logic               link;
        logic [3:0]         cond;
        logic               illegal;
    } ctrl_t;

    function automatic reg_dst_e sel_to_dst(input logic [1:0] sel);
        case (sel)
            2'd1:    return RD_X;
            2'd2:    return RD_Y;
            2'd3:    return RD_A;
            default: return RD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/accdec_operand_sel.sv
module accdec_operand_sel
    import accdec_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  mode_e              mode,
    input  logic [7:0]         imm,
    input  logic [WIDTH-1:0]   x,
    input  logic [WIDTH-1:0]   y,
    input  logic [WIDTH-1:0]   a,
    output logic [WIDTH-1:0]   operand,
    output logic               two_byte
);

    localparam int EXT_BITS = WIDTH - 8;

    logic [WIDTH-1:0] imm_ext;
    logic [WIDTH-1:0] base;

    generate
        if (EXT_BITS > 0) begin : g_wide
            assign imm_ext = {{EXT_BITS{1'b0}}, imm};
        end else begin : g_narrow
            assign imm_ext = imm[WIDTH-1:0];
        end
    endgenerate

    always_comb begin
        case (mode[1:0])
            2'd1:    base = x;
            2'd2:    base = y;
            2'd3:    base = a;
            default: base = '0;
        endcase
        two_byte = mode[2];
        operand  = mode[2] ? (base + imm_ext) : base;
    end

    always_comb begin
        if (mode == MD_IMM) begin
            assert_imm_zero_ext_R4: assert (operand == imm_ext)
                else $error("immediate mode operand mismatch");
        end
    end

endmodule

// File: rtl/accdec_ctrl_gen.sv
module accdec_ctrl_gen
    import accdec_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [4:0] opcode,
    input  mode_e      mode,
    output ctrl_t      ctrl
);

    localparam bit HAS_HIGH_MOVE = (WIDTH >= 16);

    always_comb begin
        ctrl = '0;
        if (opcode == OPC_SPECIAL) begin
            ctrl.cls[CL_ALU] = 1'b1;
            case (mode)
                MD_ZERO: ctrl.func = AF_NONE;
                MD_X: begin
                    ctrl.func     = AF_SHR;
                    ctrl.flags_we = 1'b1;
                    ctrl.dst      = RD_A;
                end
                MD_Y: begin
                    ctrl.func     = AF_ROTR;
                    ctrl.flags_we = 1'b1;
                    ctrl.dst      = RD_A;
                end
                default: ctrl.illegal = 1'b1;
            endcase
        end else if (opcode <= OPC_CMP) begin
            ctrl.cls[CL_ALU] = 1'b1;
            ctrl.func        = alu_func_e'({1'b0, opcode[2:0]});
            ctrl.flags_we    = 1'b1;
            ctrl.dst         = (opcode == OPC_CMP) ? RD_NONE : RD_A;
        end else if (opcode <= OPC_SPSET) begin
            ctrl.cls[CL_MOVE] = 1'b1;
            case (opcode)
                OPC_MVX: ctrl.dst = RD_X;
                OPC_MVY: ctrl.dst = RD_Y;
                OPC_MVA: ctrl.dst = RD_A;
                OPC_MVHI: begin
                    ctrl.dst       = RD_A;
                    ctrl.move_high = 1'b1;
                    ctrl.illegal   = !HAS_HIGH_MOVE;
                end
                default: ctrl.dst = RD_SP;
            endcase
        end else if (opcode <= OPC_LD_LAST) begin
            ctrl.cls[CL_LOAD] = 1'b1;
            ctrl.dst          = sel_to_dst(opcode[1:0]);
        end else if (opcode <= OPC_ST_LAST) begin
            ctrl.cls[CL_STORE] = 1'b1;
            ctrl.store_src     = opcode[1:0] + 2'd1;
        end else if (opcode <= OPC_JLINK) begin
            ctrl.cls[CL_JUMP] = 1'b1;
            if (opcode == OPC_JLINK) begin
                ctrl.link = 1'b1;
                ctrl.dst  = RD_Y;
            end
        end else if (opcode <= OPC_BR_LAST) begin
            ctrl.cls[CL_BRANCH] = 1'b1;
            ctrl.cond           = 4'(opcode - OPC_BR_FIRST);
        end else if (opcode == OPC_PUSH) begin
            ctrl.cls[CL_PUSH] = 1'b1;
        end else begin
            ctrl.cls[CL_POP] = 1'b1;
            ctrl.illegal     = mode[2];
            ctrl.dst         = mode[2] ? RD_NONE : sel_to_dst(mode[1:0]);
        end
    end

    always_comb begin
        assert_onehot_class_R5: assert ($onehot(ctrl.cls))
            else $error("class vector not one-hot");
        if (ctrl.flags_we) begin
            assert_flags_alu_only_R6: assert (ctrl.cls[CL_ALU] && ctrl.func != AF_NONE)
                else $error("flag write outside an ALU operation");
        end
        if (ctrl.illegal) begin
            assert_illegal_scope_R7: assert (ctrl.cls[CL_ALU] || ctrl.cls[CL_POP] || ctrl.move_high)
                else $error("illegal raised on an always-valid opcode");
        end
    end

endmodule

// File: rtl/acc_instr_decoder.sv
module acc_instr_decoder
    import accdec_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [7:0]       instr_byte,
    input  logic [7:0]       imm_byte,
    input  logic [WIDTH-1:0] reg_x,
    input  logic [WIDTH-1:0] reg_y,
    input  logic [WIDTH-1:0] reg_a,
    output logic [4:0]       opcode,
    output logic [2:0]       mode,
    output logic             two_byte,
    output logic [WIDTH-1:0] operand,
    output logic [7:0]       op_class,
    output logic [3:0]       alu_func,
    output logic             flags_we,
    output logic [2:0]       reg_dst,
    output logic [1:0]       store_src,
    output logic             move_high,
    output logic             link_en,
    output logic [3:0]       branch_cond,
    output logic             illegal
);

    mode_e mode_s;
    ctrl_t ctrl_s;

    assign opcode = instr_byte[7:3];
    assign mode_s = mode_e'(instr_byte[2:0]);
    assign mode   = mode_s;

    accdec_operand_sel #(.WIDTH(WIDTH)) u_operand (
        .mode     (mode_s),
        .imm      (imm_byte),
        .x        (reg_x),
        .y        (reg_y),
        .a        (reg_a),
        .operand  (operand),
        .two_byte (two_byte)
    );

    accdec_ctrl_gen #(.WIDTH(WIDTH)) u_ctrl (
        .opcode (opcode),
        .mode   (mode_s),
        .ctrl   (ctrl_s)
    );

    assign op_class    = ctrl_s.cls;
    assign alu_func    = ctrl_s.func;
    assign flags_we    = ctrl_s.flags_we;
    assign reg_dst     = ctrl_s.dst;
    assign store_src   = ctrl_s.store_src;
    assign move_high   = ctrl_s.move_high;
    assign link_en     = ctrl_s.link;
    assign branch_cond = ctrl_s.cond;
    assign illegal     = ctrl_s.illegal;

    always_comb begin
        if (!instr_byte[2]) begin
            assert_short_operand_R3: assert (operand == '0 || operand == reg_x ||
                                             operand == reg_y || operand == reg_a)
                else $error("short-form operand not from a register or zero");
        end
        if (op_class[7] && !illegal) begin
            assert_pop_dest_R9: assert (reg_dst <= 3'd3)
                else $error("pop destination out of range");
        end
        if (store_src != 2'd0) begin
            assert_store_class_R12: assert (op_class == 8'h08)
                else $error("store source outside a store");
        end
        if (branch_cond != 4'd0) begin
            assert_cond_branch_R11: assert (op_class == 8'h20)
                else $error("condition outside a branch");
        end
    end

endmodule

// File: tb/acc_instr_decoder_tb.sv
module acc_instr_decoder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 17;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0]  instr, imm;
    logic [15:0] rx, ry, ra;
    logic [4:0]  opc;
    logic [2:0]  md;
    logic        two;
    logic [15:0] opnd;
    logic [7:0]  cls;
    logic [3:0]  func;
    logic        fwe;
    logic [2:0]  dst;
    logic [1:0]  ssrc;
    logic        mhi, lnk, ill;
    logic [3:0]  cond;

    logic [7:0]  rx8, ry8, ra8;
    logic [4:0]  opc8;
    logic [2:0]  md8;
    logic        two8;
    logic [7:0]  opnd8;
    logic [7:0]  cls8;
    logic [3:0]  func8;
    logic        fwe8;
    logic [2:0]  dst8;
    logic [1:0]  ssrc8;
    logic        mhi8, lnk8, ill8;
    logic [3:0]  cond8;

    acc_instr_decoder #(.WIDTH(16)) dut_i (
        .instr_byte(instr), .imm_byte(imm), .reg_x(rx), .reg_y(ry), .reg_a(ra),
        .opcode(opc), .mode(md), .two_byte(two), .operand(opnd), .op_class(cls),
        .alu_func(func), .flags_we(fwe), .reg_dst(dst), .store_src(ssrc),
        .move_high(mhi), .link_en(lnk), .branch_cond(cond), .illegal(ill)
    );

    acc_instr_decoder #(.WIDTH(8)) dut8_i (
        .instr_byte(instr), .imm_byte(imm), .reg_x(rx8), .reg_y(ry8), .reg_a(ra8),
        .opcode(opc8), .mode(md8), .two_byte(two8), .operand(opnd8), .op_class(cls8),
        .alu_func(func8), .flags_we(fwe8), .reg_dst(dst8), .store_src(ssrc8),
        .move_high(mhi8), .link_en(lnk8), .branch_cond(cond8), .illegal(ill8)
    );

    // {instr, imm, operand, class, func, dst, illegal, two_byte} with X=1234 Y=00F0 A=FFF0
    localparam logic [48:0] VEC [NV] = '{
        {8'h0B, 8'h00, 16'hFFF0, 8'h01, 4'd1, 3'd3, 1'b0, 1'b0},
        {8'h15, 8'h10, 16'h1244, 8'h01, 4'd2, 3'd3, 1'b0, 1'b1},
        {8'h3C, 8'hAB, 16'h00AB, 8'h01, 4'd7, 3'd0, 1'b0, 1'b1},
        {8'h42, 8'h00, 16'h00F0, 8'h02, 4'd0, 3'd1, 1'b0, 1'b0},
        {8'h66, 8'h20, 16'h0110, 8'h02, 4'd0, 3'd4, 1'b0, 1'b1},
        {8'h7F, 8'h20, 16'h0010, 8'h04, 4'd0, 3'd3, 1'b0, 1'b1},
        {8'h89, 8'h00, 16'h1234, 8'h08, 4'd0, 3'd0, 1'b0, 1'b0},
        {8'hA0, 8'h00, 16'h0000, 8'h10, 4'd0, 3'd2, 1'b0, 1'b0},
        {8'hC4, 8'hFF, 16'h00FF, 8'h20, 4'd0, 3'd0, 1'b0, 1'b1},
        {8'hF3, 8'h00, 16'hFFF0, 8'h40, 4'd0, 3'd0, 1'b0, 1'b0},
        {8'hFA, 8'h00, 16'h00F0, 8'h80, 4'd0, 3'd2, 1'b0, 1'b0},
        {8'hFD, 8'h01, 16'h1235, 8'h80, 4'd0, 3'd0, 1'b1, 1'b1},
        {8'h01, 8'h00, 16'h1234, 8'h01, 4'd8, 3'd3, 1'b0, 1'b0},
        {8'h02, 8'h00, 16'h00F0, 8'h01, 4'd9, 3'd3, 1'b0, 1'b0},
        {8'h04, 8'h55, 16'h0055, 8'h01, 4'd0, 3'd0, 1'b1, 1'b1},
        {8'h00, 8'h00, 16'h0000, 8'h01, 4'd0, 3'd0, 1'b0, 1'b0},
        {8'h5C, 8'h12, 16'h0012, 8'h02, 4'd0, 3'd3, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] ib, input logic [7:0] im);
        @(negedge clk);
        instr = ib;
        imm   = im;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        instr = 8'h00; imm = 8'h00;
        rx = 16'h1234; ry = 16'h00F0; ra = 16'hFFF0;
        rx8 = 8'hF0; ry8 = 8'h7F; ra8 = 8'h01;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Idle state: all-zero byte is a no-operation
        apply(8'h00, 8'h00);
        chk("R7", "idle class", 32'(cls), 32'h01);
        chk("R7", "idle illegal", 32'(ill), 32'h0);
        chk("R3", "idle operand", 32'(opnd), 32'h0);
        chk("R6", "idle flags_we", 32'(fwe), 32'h0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][48:41], VEC[i][40:33]);
            chk("R3/R4", $sformatf("vec %0d operand", i), 32'(opnd), 32'(VEC[i][32:17]));
            chk("R5", $sformatf("vec %0d class", i), 32'(cls), 32'(VEC[i][16:9]));
            chk("R6", $sformatf("vec %0d func", i), 32'(func), 32'(VEC[i][8:5]));
            chk("R8", $sformatf("vec %0d dst", i), 32'(dst), 32'(VEC[i][4:2]));
            chk("R9", $sformatf("vec %0d illegal", i), 32'(ill), 32'(VEC[i][1]));
            chk("R2", $sformatf("vec %0d two_byte", i), 32'(two), 32'(VEC[i][0]));
        end

        // R1 field split
        apply(8'hB5, 8'h00);
        chk("R1", "opcode", 32'(opc), 32'h16);
        chk("R1", "mode", 32'(md), 32'h5);

        // R6 flag writes
        apply(8'h3B, 8'h00);
        chk("R6", "compare flags_we", 32'(fwe), 32'h1);
        apply(8'h01, 8'h00);
        chk("R6", "shift flags_we", 32'(fwe), 32'h1);
        apply(8'h53, 8'h00);
        chk("R6", "move flags_we", 32'(fwe), 32'h0);
        apply(8'h07, 8'h00);
        chk("R7", "special 111 flags_we", 32'(fwe), 32'h0);
        chk("R7", "special 111 illegal", 32'(ill), 32'h1);
        apply(8'h03, 8'h00);
        chk("R7", "special 011 illegal", 32'(ill), 32'h1);

        // R8 link and range edges
        apply(8'hA0, 8'h00);
        chk("R8", "link_en", 32'(lnk), 32'h1);
        apply(8'h98, 8'h00);
        chk("R8", "plain jump link_en", 32'(lnk), 32'h0);
        chk("R5", "plain jump class", 32'(cls), 32'h10);
        apply(8'h68, 8'h00);
        chk("R8", "load X dst", 32'(dst), 32'h1);
        chk("R5", "load X class", 32'(cls), 32'h04);

        // R9 pop discard
        apply(8'hF8, 8'h00);
        chk("R9", "pop discard dst", 32'(dst), 32'h0);
        chk("R9", "pop discard illegal", 32'(ill), 32'h0);

        // R10 high move by width
        apply(8'h5B, 8'h00);
        chk("R10", "move_high w16", 32'(mhi), 32'h1);
        chk("R10", "illegal w16", 32'(ill), 32'h0);
        chk("R10", "illegal w8", 32'(ill8), 32'h1);
        chk("R10", "move_high w8", 32'(mhi8), 32'h1);

        // R11 branch conditions
        apply(8'hA8, 8'h00);
        chk("R11", "always cond", 32'(cond), 32'h0);
        chk("R5", "always class", 32'(cls), 32'h20);
        apply(8'hB8, 8'h00);
        chk("R11", "carry set cond", 32'(cond), 32'h2);
        apply(8'hE8, 8'h00);
        chk("R11", "overflow clear cond", 32'(cond), 32'h8);
        apply(8'hF0, 8'h00);
        chk("R11", "push cond", 32'(cond), 32'h0);

        // R12 store source
        apply(8'h80, 8'h00);
        chk("R12", "store X src", 32'(ssrc), 32'h1);
        apply(8'h90, 8'h00);
        chk("R12", "store A src", 32'(ssrc), 32'h3);
        apply(8'h78, 8'h00);
        chk("R12", "load src", 32'(ssrc), 32'h0);

        // R4 narrow wrap and immediate
        apply(8'h0D, 8'h20);
        chk("R4", "w8 X+imm wrap", 32'(opnd8), 32'h10);
        apply(8'h0C, 8'hC3);
        chk("R4", "w8 imm", 32'(opnd8), 32'hC3);
        chk("R4", "w16 imm zero-ext", 32'(opnd), 32'h00C3);
        apply(8'h0F, 8'h80);
        chk("R4", "w16 A+imm", 32'(opnd), 32'h0070);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule